// File: doc/BRIEF.md
# Instruction Fault Status System Register

This block holds the 64-bit instruction fault status word that a hypervisor-level agent reads and writes through the system-register access port. Software accesses carry an opcode tuple (op0, op1, CRn, CRm, op2), a read/write flag and the current exception level. The block decides in the same cycle whether the access succeeds, is undefined, or traps to the hypervisor level. A trap comes with a syndrome class. Read data for a successful read is returned in the same cycle.

A separate capture port loads a fresh fault status when an instruction abort is taken. The stored word has two field layouts, chosen by a translation-format control input. The layout decides where the fault status code sits and which bits are forced to zero. A captured fault has its external-abort-type bit and address-invalid bit cleared unless the status code allows them.

Top module: `ifault_status_reg`

## Requirements
- R1: The register is selected only when `acc_valid` is high and the tuple is op0=2'b11, op1=3'b100, CRn=4'b0101, CRm=4'b0000, op2=3'b001. Any other tuple gives `acc_hit`=0, `acc_ok`=`acc_undef`=`acc_trap`=0, `rdata`=0, and leaves the register unchanged.
- R2: When `lower_aa32_ok` is 0, every selected access gives `acc_undef`=1, whatever `cur_el` is.
- R3: A selected access with `cur_el`=0 gives `acc_undef`=1.
- R4: A selected access with `cur_el`=1 gives `acc_trap`=1 and `trap_class`=6'h18 when `nv_trap_en`=1. When `nv_trap_en`=0 it gives `acc_undef`=1. `trap_class` is 0 whenever `acc_trap` is 0.
- R5: A selected access with `cur_el`=2 or 3 gives `acc_ok`=1. A read returns the stored word on `rdata` in the same cycle. A write updates the register at the next clock edge.
- R6: `rdata[63:17]` is always zero. `rdata` is zero for any access that is not a successful read.
- R7: With `long_fmt`=0, the live bits are 16, 12, 10, 9 and 3:0. Bit 10 is the top bit of the 5-bit fault status and bits 3:0 are its lower bits. Bits 15:13, 11 and 8:4 read zero and are dropped on write.
- R8: With `long_fmt`=1, the live bits are 16, 12, 9 and 5:0, and bits 5:0 hold the 6-bit fault status. Bits 15:13, 11:10 and 8:6 read zero and are dropped on write.
- R9: Bit 9 (table-format flag) is stored and returned as written, in both layouts, and changes no other behaviour.
- R10: A capture (`cap_valid`=1) places `cap_status` per the active layout and sets bit 9 from `cap_fmt`.
  - Bit 12 takes `cap_ext_type` only for external-abort codes: 5'b01000, 5'b01100 or 5'b01110 with `long_fmt`=0, and 6'b010000 or 6'b010101 to 6'b010111 with `long_fmt`=1. Otherwise bit 12 is 0.
  - Bit 16 takes `cap_addr_invalid` only for the non-walk synchronous external abort: 5'b01000 with `long_fmt`=0, or 6'b010000 with `long_fmt`=1. Otherwise bit 16 is 0.
- R11: A capture in the same cycle as a successful write wins; the written data is lost.
- R12: A trapped or undefined write leaves the register unchanged.
- R13: After reset the register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Software access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Opcode op0 |
| acc_op1 | input | 3 | Opcode op1 |
| acc_crn | input | 4 | Opcode CRn |
| acc_crm | input | 4 | Opcode CRm |
| acc_op2 | input | 3 | Opcode op2 |
| cur_el | input | 2 | Current exception level |
| nv_trap_en | input | 1 | Nested-virtualisation trap control |
| lower_aa32_ok | input | 1 | Lower level can use the 32-bit state |
| long_fmt | input | 1 | Field layout select (1 = 6-bit status) |
| wdata | input | 64 | Write data |
| cap_valid | input | 1 | Hardware fault capture strobe |
| cap_status | input | 6 | Captured fault status code |
| cap_ext_type | input | 1 | Captured external-abort type |
| cap_addr_invalid | input | 1 | Captured fault-address-invalid flag |
| cap_fmt | input | 1 | Captured table-format flag |
| rdata | output | 64 | Read data |
| acc_hit | output | 1 | Access selects this register |
| acc_ok | output | 1 | Access succeeds |
| acc_undef | output | 1 | Access is undefined |
| acc_trap | output | 1 | Access traps to the hypervisor level |
| trap_class | output | 6 | Trap syndrome class |

## Verification
The access verdict, the trap class and read data are combinational, so they are due in the request cycle itself. The bench drives every request at a falling edge and samples one nanosecond later, before the next rising edge. Writes and captures take effect at the next rising edge, so their effect is checked by a read in the following cycle. The same later read confirms that refused writes left the register untouched.

// File: rtl/fsr_pkg.sv
// Shared constants, types and helper functions for the fault status register.
// Assumes: only the low LIVE_W bits of the 64-bit word can ever be nonzero.
package fsr_pkg;

    localparam int REG_W  = 64;
    localparam int LIVE_W = 17;
    localparam int STAT_W = 6;

    localparam logic [1:0] SEL_OP0 = 2'b11;
    localparam logic [2:0] SEL_OP1 = 3'b100;
    localparam logic [3:0] SEL_CRN = 4'b0101;
    localparam logic [3:0] SEL_CRM = 4'b0000;
    localparam logic [2:0] SEL_OP2 = 3'b001;

    localparam logic [STAT_W-1:0] TRAP_EC = 6'h18;

    localparam int B_FNV = 16;
    localparam int B_EXT = 12;
    localparam int B_FMT = 9;
    localparam int B_S4  = 10;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_OK    = 2'd1,
        RES_UNDEF = 2'd2,
        RES_TRAP  = 2'd3
    } acc_res_e;

    // Live-bit mask of the active layout.
    function automatic logic [LIVE_W-1:0] layout_mask(input logic lng);
        logic [LIVE_W-1:0] m;
        m = '0;
        m[B_FNV] = 1'b1;
        m[B_EXT] = 1'b1;
        m[B_FMT] = 1'b1;
        if (lng) begin
            m[5:0] = 6'h3F;
        end else begin
            m[B_S4] = 1'b1;
            m[3:0]  = 4'hF;
        end
        return m;
    endfunction

    // Status code denotes an external abort (walk or not).
    function automatic logic is_ext_abort(input logic lng, input logic [STAT_W-1:0] s);
        if (lng)
            return (s == 6'b010000) || (s == 6'b010101) ||
                   (s == 6'b010110) || (s == 6'b010111);
        else
            return (s[4:0] == 5'b01000) || (s[4:0] == 5'b01100) ||
                   (s[4:0] == 5'b01110);
    endfunction

    // Status code denotes a synchronous external abort not on a table walk.
    function automatic logic is_ext_nowalk(input logic lng, input logic [STAT_W-1:0] s);
        if (lng)
            return s == 6'b010000;
        else
            return s[4:0] == 5'b01000;
    endfunction

endpackage

// File: rtl/fsr_access_ctrl.sv
// Access decision for the fault status register.
// Decodes the opcode tuple and grants, refuses or traps each request from
// the exception level and the capability/trap controls. Purely combinational;
// the clock and reset only serve the embedded assertions.
module fsr_access_ctrl
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        op0,
    input  logic [2:0]        op1,
    input  logic [3:0]        crn,
    input  logic [3:0]        crm,
    input  logic [2:0]        op2,
    input  logic [1:0]        cur_el,
    input  logic              nv_trap_en,
    input  logic              lower_aa32_ok,
    output logic              hit,
    output acc_res_e          result,
    output logic [STAT_W-1:0] trap_class
);

    // Tuple match for this register.
    always_comb begin
        hit = acc_valid && (op0 == SEL_OP0) && (op1 == SEL_OP1) &&
              (crn == SEL_CRN) && (crm == SEL_CRM) && (op2 == SEL_OP2);
    end

    // Verdict by capability, then level, then trap control.
    always_comb begin
        result = RES_NONE;
        if (hit) begin
            if (!lower_aa32_ok)        result = RES_UNDEF;
            else if (cur_el == 2'd0)   result = RES_UNDEF;
            else if (cur_el == 2'd1)   result = nv_trap_en ? RES_TRAP : RES_UNDEF;
            else                       result = RES_OK;
        end
    end

    // Syndrome class only accompanies a trap.
    always_comb begin
        trap_class = (result == RES_TRAP) ? TRAP_EC : '0;
    end

    // R2
    no_cap_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !lower_aa32_ok) |-> (result == RES_UNDEF));
    // R3
    el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cur_el == 2'd0) |-> (result == RES_UNDEF));
    // R4
    trap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result == RES_TRAP) |-> (cur_el == 2'd1 && nv_trap_en && lower_aa32_ok));
    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (result == RES_NONE));

endmodule

// File: rtl/fsr_field_fmt.sv
// Field formatting for the fault status register.
// Builds the masked write word, the capture word and the read view for the
// active layout. Assumes the layout select is stable for the duration of an access.
module fsr_field_fmt
    import fsr_pkg::*;
(
    input  logic              long_fmt,
    input  logic [LIVE_W-1:0] wr_raw,
    input  logic [STAT_W-1:0] cap_status,
    input  logic              cap_ext_type,
    input  logic              cap_addr_invalid,
    input  logic              cap_fmt,
    input  logic [LIVE_W-1:0] stored,
    output logic [LIVE_W-1:0] wr_word,
    output logic [LIVE_W-1:0] cap_word,
    output logic [LIVE_W-1:0] rd_view
);

    logic [LIVE_W-1:0] mask;

    // Live-bit mask of the current layout.
    always_comb mask = layout_mask(long_fmt);

    // Software write keeps only live bits.
    always_comb wr_word = wr_raw & mask;

    // Capture word: place status, qualify abort flags.
    always_comb begin
        cap_word = '0;
        if (long_fmt) begin
            cap_word[5:0] = cap_status;
        end else begin
            cap_word[B_S4] = cap_status[4];
            cap_word[3:0]  = cap_status[3:0];
        end
        cap_word[B_FMT] = cap_fmt;
        cap_word[B_EXT] = cap_ext_type && is_ext_abort(long_fmt, cap_status);
        cap_word[B_FNV] = cap_addr_invalid && is_ext_nowalk(long_fmt, cap_status);
    end

    // Read view of the stored word under the current layout.
    always_comb rd_view = stored & mask;

endmodule

// File: rtl/fsr_store.sv
// State holder for the fault status register.
// A hardware capture takes precedence over a software write; otherwise the
// state holds. Synchronous active-low reset clears it.
module fsr_store
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [LIVE_W-1:0] cap_word,
    input  logic              wr_en,
    input  logic [LIVE_W-1:0] wr_word,
    output logic [LIVE_W-1:0] state
);

    // Register update with capture priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= '0;
        else if (cap_en) state <= cap_word;
        else if (wr_en)  state <= wr_word;
    end

    // R11
    cap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (state == $past(cap_word)));
    // R5
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cap_en) |=> (state == $past(wr_word)));
    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cap_en) |=> $stable(state));

endmodule

// File: rtl/ifault_status_reg.sv
// Instruction fault status system register, top level.
// Joins access decision, field formatting and state. All access results are
// combinational in the request cycle; writes and captures land at the next edge.
module ifault_status_reg
    import fsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  acc_op0,
    input  logic [2:0]  acc_op1,
    input  logic [3:0]  acc_crn,
    input  logic [3:0]  acc_crm,
    input  logic [2:0]  acc_op2,
    input  logic [1:0]  cur_el,
    input  logic        nv_trap_en,
    input  logic        lower_aa32_ok,
    input  logic        long_fmt,
    input  logic [63:0] wdata,
    input  logic        cap_valid,
    input  logic [5:0]  cap_status,
    input  logic        cap_ext_type,
    input  logic        cap_addr_invalid,
    input  logic        cap_fmt,
    output logic [63:0] rdata,
    output logic        acc_hit,
    output logic        acc_ok,
    output logic        acc_undef,
    output logic        acc_trap,
    output logic [5:0]  trap_class
);

    acc_res_e          res;
    logic [LIVE_W-1:0] wr_word, cap_word, rd_view, state;
    logic              wr_en;

    fsr_access_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
        .op0(acc_op0), .op1(acc_op1), .crn(acc_crn), .crm(acc_crm), .op2(acc_op2),
        .cur_el(cur_el), .nv_trap_en(nv_trap_en), .lower_aa32_ok(lower_aa32_ok),
        .hit(acc_hit), .result(res), .trap_class(trap_class)
    );

    fsr_field_fmt u_fmt (
        .long_fmt(long_fmt), .wr_raw(wdata[LIVE_W-1:0]),
        .cap_status(cap_status), .cap_ext_type(cap_ext_type),
        .cap_addr_invalid(cap_addr_invalid), .cap_fmt(cap_fmt),
        .stored(state), .wr_word(wr_word), .cap_word(cap_word), .rd_view(rd_view)
    );

    fsr_store u_store (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_valid), .cap_word(cap_word),
        .wr_en(wr_en), .wr_word(wr_word), .state(state)
    );

    // Verdict flags from the decision.
    always_comb begin
        acc_ok    = (res == RES_OK);
        acc_undef = (res == RES_UNDEF);
        acc_trap  = (res == RES_TRAP);
    end

    // Only a granted write reaches the state.
    always_comb wr_en = acc_ok && acc_write;

    // Read data only for a granted read, zero-extended.
    always_comb begin
        rdata = '0;
        if (acc_ok && !acc_write) rdata[LIVE_W-1:0] = rd_view;
    end

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[63:17] == '0);
    // R7
    short_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !long_fmt |-> (rdata[15:13] == '0 && !rdata[11] && rdata[8:4] == '0));
    // R8
    long_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        long_fmt |-> (rdata[15:13] == '0 && rdata[11:10] == '0 && rdata[8:6] == '0));
    // R4
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_ok, acc_undef, acc_trap}) && (acc_trap == (trap_class == 6'h18)));
    // R6
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_ok && !acc_write) |-> (rdata == '0));

endmodule

// File: tb/test_ifault_status_reg.sv
module test_ifault_status_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_write = 0;
    logic [1:0]  acc_op0 = 2'b11;
    logic [2:0]  acc_op1 = 3'b100;
    logic [3:0]  acc_crn = 4'b0101;
    logic [3:0]  acc_crm = 4'b0000;
    logic [2:0]  acc_op2 = 3'b001;
    logic [1:0]  cur_el = 2'd2;
    logic        nv_trap_en = 0, lower_aa32_ok = 1, long_fmt = 0;
    logic [63:0] wdata = '0;
    logic        cap_valid = 0;
    logic [5:0]  cap_status = '0;
    logic        cap_ext_type = 0, cap_addr_invalid = 0, cap_fmt = 0;
    logic [63:0] rdata;
    logic        acc_hit, acc_ok, acc_undef, acc_trap;
    logic [5:0]  trap_class;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    ifault_status_reg i_ifault_status_reg (.*);

    // Vector: el, nv, aa32, lng, wr, wdata, verdict(0 none 1 ok 2 undef 3 trap), rdata
    typedef struct packed {
        logic [1:0]  el;
        logic        nv;
        logic        aa32;
        logic        lng;
        logic        wr;
        logic [63:0] wd;
        logic [1:0]  vd;
        logic [63:0] rd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 64'h0},       // R5 R7 write
        '{2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 2'd1, 64'h1160F},                     // R5 R7 R6 read
        '{2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0, 2'd1, 64'h1120F},                     // R8 view
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0, 2'd3, 64'h0},                         // R4 trap write
        '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 2'd2, 64'h0},                         // R4 undef
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0, 2'd2, 64'h0},                         // R3
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0, 2'd2, 64'h0},                         // R2
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 2'd1, 64'h1160F},                     // R12 unchanged
        '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0200, 2'd1, 64'h0},       // R8 R9 write
        '{2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0, 2'd1, 64'h200},                       // R9
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 2'd1, 64'h200}                        // R9 other layout
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_verdict(input string tag, input logic [1:0] vd);
        chk({tag, " ok"},    {63'd0, acc_ok},    {63'd0, vd == 2'd1});
        chk({tag, " undef"}, {63'd0, acc_undef}, {63'd0, vd == 2'd2});
        chk({tag, " trap"},  {63'd0, acc_trap},  {63'd0, vd == 2'd3});
        chk({tag, " class"}, {58'd0, trap_class}, (vd == 2'd3) ? 64'h18 : 64'h0);
    endtask

    // One access: drive at falling edge, sample 1 ns later.
    task automatic access(input logic [1:0] el, input logic nv, input logic aa32,
                          input logic lng, input logic wr, input logic [63:0] wd);
        @(negedge clk);
        acc_valid = 1; cur_el = el; nv_trap_en = nv; lower_aa32_ok = aa32;
        long_fmt = lng; acc_write = wr; wdata = wd;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 0; acc_write = 0; cap_valid = 0;
    endtask

    task automatic capture(input logic lng, input logic [5:0] st, input logic ext,
                           input logic fnv, input logic fmt);
        @(negedge clk);
        acc_valid = 0; long_fmt = lng; cap_valid = 1; cap_status = st;
        cap_ext_type = ext; cap_addr_invalid = fnv; cap_fmt = fmt;
        @(negedge clk);
        cap_valid = 0;
    endtask

    task automatic read_chk(input string tag, input logic lng, input logic [63:0] exp);
        access(2'd2, 1'b0, 1'b1, lng, 1'b0, 64'h0);
        chk(tag, rdata, exp);
        idle();
    endtask

    // Watchdog: a hung run fails and still summarises.
    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13 reset state
        read_chk("R13 reset value", 1'b0, 64'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].el, VEC[i].nv, VEC[i].aa32, VEC[i].lng, VEC[i].wr, VEC[i].wd);
            chk_verdict($sformatf("table %0d", i), VEC[i].vd);
            chk($sformatf("table %0d rdata", i), rdata, VEC[i].rd);
            chk($sformatf("table %0d hit", i), {63'd0, acc_hit}, 64'd1);
        end
        idle();

        // R1 non-matching tuple: quiet and no write
        access(2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 64'hF);
        acc_crm = 4'b0001; #0.5;
        chk("R1 miss hit", {63'd0, acc_hit}, 64'd0);
        chk_verdict("R1 miss", 2'd0);
        acc_write = 0; #0.5;
        chk("R1 miss rdata", rdata, 64'h0);
        idle(); acc_crm = 4'b0000;
        read_chk("R1 miss no write", 1'b0, 64'h200);
        access(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0);
        acc_op1 = 3'b000; #0.5;
        chk("R1 op1 miss rdata", rdata, 64'h0);
        idle(); acc_op1 = 3'b100;

        // R10 captures
        capture(1'b0, 6'b001000, 1, 1, 0);
        read_chk("R10 short nowalk ext", 1'b0, 64'h11008);
        capture(1'b0, 6'b000101, 1, 1, 1);
        read_chk("R10 short non-ext", 1'b0, 64'h205);
        capture(1'b0, 6'b001100, 1, 1, 0);
        read_chk("R10 short walk ext", 1'b0, 64'h100C);
        capture(1'b0, 6'b010000, 0, 0, 0);
        read_chk("R10 R7 status bit10", 1'b0, 64'h400);
        capture(1'b1, 6'b010101, 1, 1, 0);
        read_chk("R10 long walk ext", 1'b1, 64'h1015);
        capture(1'b1, 6'b010000, 1, 1, 1);
        read_chk("R10 long nowalk ext", 1'b1, 64'h11210);
        capture(1'b1, 6'b110000, 1, 1, 0);
        read_chk("R10 R8 long tlb", 1'b1, 64'h30);

        // R11 capture beats same-cycle write
        @(negedge clk);
        acc_valid = 1; acc_write = 1; cur_el = 2'd3; lower_aa32_ok = 1;
        long_fmt = 0; wdata = 64'h1F; cap_valid = 1; cap_status = 6'b000111;
        cap_ext_type = 0; cap_addr_invalid = 0; cap_fmt = 0;
        #1;
        chk("R11 write granted", {63'd0, acc_ok}, 64'd1);
        idle();
        read_chk("R11 capture wins", 1'b0, 64'h7);

        // R12 trapped write leaves state
        access(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 64'h1F);
        idle();
        read_chk("R12 after trap", 1'b0, 64'h7);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule